// File: doc/BRIEF.md
# Frame Check Sequence Appender

This block sits on the transmit side of a MAC and appends the 32-bit frame check sequence to each outgoing frame. Octets enter one per cycle on a byte-wide valid/ready/last interface. Each accepted octet is passed to the output stream one cycle later. It is also folded into a bit-serial CRC32 register, starting with bit 0 of the octet and ending with bit 7, which is the order the bits leave on the wire.

When the octet marked last has been accepted, the block closes its input for four cycles. In those cycles it emits the four check octets, so that the full stream read in transmit order carries the correct remainder. A start-of-frame strobe presets the remainder. It also abandons any check-octet sequence that is still running.

Top module: `crc32_fcs_tx`

## Requirements
- R1: During and right after reset, `in_ready` is 1, and both `out_valid` and `out_last` are 0.
- R2: An octet accepted when `in_valid` and `in_ready` are both high appears on `out_data` with `out_valid` high and `out_last` low in the next cycle.
- R3: In a cycle with no accepted octet and no check octet pending, `out_valid` is low in the following cycle.
- R4: The remainder follows CRC32 with generator polynomial 0x04C11DB7. The register is preset to all ones, and each octet is fed bit 0 first. The transmitted value X is the complement of the final register. X is sent most significant coefficient first.
- R5: Check octet k (k = 0..3) appears k+2 cycles after the last payload octet was accepted. Its bit j equals bit 31-8k-j of X. For the ASCII payload "123456789" the octets are 26 39 F4 CB.
- R6: `out_last` is high only together with the fourth check octet.
- R7: `in_ready` is low for the four cycles that follow acceptance of a last octet. `in_valid` is ignored in those cycles, and it changes neither the check octets nor the next frame.
- R8: `sof` presets the remainder, so that an octet presented with `sof` is the first octet of a new frame. A `sof` pulse during the check octets stops them: in the next cycle `out_valid` is low and `in_ready` is high.
- R9: The check octets never equal the value obtained by feeding each octet bit 7 first. They also never equal that value with each of its octets bit-reversed.
- R10: After the fourth check octet the remainder is preset again on its own, so frames sent back to back need no `sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame clear of the remainder |
| in_valid | input | 1 | Input octet valid |
| in_data | input | 8 | Input octet |
| in_last | input | 1 | Marks the final payload octet |
| in_ready | output | 1 | Block can take an octet |
| out_valid | output | 1 | Output octet valid |
| out_data | output | 8 | Payload octet or check octet |
| out_last | output | 1 | Final check octet of the frame |

## Verification
A payload octet is due one cycle after the edge that accepts it. Check octet k is due k+2 cycles after the last payload octet was accepted. `in_ready` falls one cycle after that acceptance and rises with the fourth check octet. The bench drives inputs on the falling edge and reads each output on the next falling edge, so each comparison falls exactly one register stage after its stimulus. Expected check octets come from a non-reflected shift-left model that is independent of the RTL's reflected form. The same model, fed bit 7 first, yields the two wrong values that must never appear.

// File: rtl/crc32_fcs_tx.sv
module crc32_fcs_tx #(
  parameter int          CRC_W    = 32,
  parameter logic [31:0] POLY_REV = 32'hEDB88320,
  parameter int          N_FCS    = CRC_W / 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int CNT_W = (N_FCS > 1) ? $clog2(N_FCS) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(N_FCS - 1);

  logic [CRC_W-1:0] crc_q, crc_base, crc_nxt;
  logic             fcs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign in_ready = !fcs_q;
  assign accept   = in_valid && in_ready;
  assign crc_base = sof ? '1 : crc_q;

  always_comb begin
    crc_nxt = crc_base;
    for (int i = 0; i < 8; i++)
      crc_nxt = (crc_nxt >> 1) ^ ((crc_nxt[0] ^ in_data[i]) ? POLY_REV : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q     <= '1;
      fcs_q     <= 1'b0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (accept) begin
        crc_q     <= crc_nxt;
        out_valid <= 1'b1;
        out_data  <= in_data;
        fcs_q     <= in_last;
        cnt_q     <= '0;
      end else if (sof) begin
        crc_q <= '1;
        fcs_q <= 1'b0;
      end else if (fcs_q) begin
        out_valid <= 1'b1;
        out_data  <= ~crc_q[{cnt_q, 3'b000} +: 8];
        out_last  <= (cnt_q == CNT_END);
        cnt_q     <= cnt_q + 1'b1;
        if (cnt_q == CNT_END) begin
          fcs_q <= 1'b0;
          crc_q <= '1;
        end
      end
    end
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && !out_last && out_data == $past(in_data))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !out_valid); // R3
  AST_FCS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !sof) |=> out_valid); // R5
  AST_LAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_last); // R6
  AST_LAST_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (in_ready && out_valid)); // R7
  AST_CLOSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready); // R7
  AST_SOF_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !in_ready) |=> (in_ready && !out_valid)); // R8
endmodule

// File: tb/sim_crc32_fcs_tx.sv
`timescale 1ns/1ps
module sim_crc32_fcs_tx;
  logic clk = 0, rst_n = 0, sof = 0, in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;
  int checks = 0, fails = 0;
  logic [7:0] frm [0:127];
  logic [7:0] got [0:3];

  always #10 clk = ~clk;

  crc32_fcs_tx u0 (.clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_ref(input int n, input bit msbf);
    logic [31:0] c = '1;
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++) begin
        logic d, fb;
        d  = msbf ? frm[b][7-i] : frm[b][i];
        fb = c[31] ^ d;
        c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    return ~c;
  endfunction

  function automatic logic [7:0] wire_oct(input logic [31:0] x, input int k);
    logic [7:0] o;
    for (int j = 0; j < 8; j++) o[j] = x[31-8*k-j];
    return o;
  endfunction

  function automatic logic [31:0] rev_oct(input logic [31:0] w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 8; j++) r[8*k+j] = w[8*k+7-j];
    return r;
  endfunction

  task automatic send_frame(input int n, input bit gaps, input bit junk, input bit first_sof);
    logic [31:0] x, w, g;
    x = crc_ref(n, 0);
    w = crc_ref(n, 1);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        in_valid = 0; in_last = 0; in_data = 8'($urandom);
        @(negedge clk);
        chk(!out_valid, "R3", {31'b0, out_valid}, 0);
      end
      sof = first_sof && (i == 0);
      in_valid = 1; in_data = frm[i]; in_last = (i == n-1);
      @(negedge clk);
      sof = 0;
      chk(out_valid && !out_last && out_data == frm[i], "R2", {23'b0, out_valid, out_data}, {23'b0, 1'b1, frm[i]});
    end
    chk(!in_ready, "R7", {31'b0, in_ready}, 0);
    for (int k = 0; k < 4; k++) begin
      in_valid = junk; in_data = 8'($urandom); in_last = 1'($urandom);
      @(negedge clk);
      got[k] = out_data;
      chk(out_valid && out_data == wire_oct(x, k), "R4", {24'b0, out_data}, {24'b0, wire_oct(x, k)});
      chk(out_last == (k == 3), "R6", {31'b0, out_last}, {31'b0, k == 3});
      chk(in_ready == (k == 3), "R7", {31'b0, in_ready}, {31'b0, k == 3});
    end
    in_valid = 0; in_last = 0;
    g = {got[0], got[1], got[2], got[3]};
    chk(g != w && g != rev_oct(w), "R9", g, w);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid && !out_last, "R1", {29'b0, in_ready, out_valid, out_last}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready && !out_valid && !out_last, "R1", {29'b0, in_ready, out_valid, out_last}, 32'h4);

    for (int i = 0; i < 9; i++) frm[i] = 8'h31 + 8'(i);
    send_frame(9, 0, 0, 0);
    chk({got[0], got[1], got[2], got[3]} == 32'h2639F4CB, "R5", {got[0], got[1], got[2], got[3]}, 32'h2639F4CB);

    frm[0] = 8'h01;
    send_frame(1, 0, 1, 0);

    for (int i = 0; i < 9; i++) frm[i] = 8'h31 + 8'(i);
    send_frame(9, 0, 1, 0);
    chk({got[0], got[1], got[2], got[3]} == 32'h2639F4CB, "R10", {got[0], got[1], got[2], got[3]}, 32'h2639F4CB);

    for (int t = 0; t < 40; t++) begin
      int n;
      n = 1 + int'($urandom % 64);
      for (int i = 0; i < n; i++) frm[i] = 8'($urandom);
      send_frame(n, 1, t[0], 0);
    end

    for (int i = 0; i < 3; i++) begin
      in_valid = 1; in_data = 8'($urandom); in_last = 0;
      @(negedge clk);
    end
    for (int i = 0; i < 9; i++) frm[i] = 8'h31 + 8'(i);
    send_frame(9, 0, 0, 1);
    chk({got[0], got[1], got[2], got[3]} == 32'h2639F4CB, "R8", {got[0], got[1], got[2], got[3]}, 32'h2639F4CB);

    frm[0] = 8'h5E;
    in_valid = 1; in_data = frm[0]; in_last = 1;
    @(negedge clk);
    in_valid = 0; in_last = 0; sof = 1;
    @(negedge clk);
    sof = 0;
    chk(!out_valid && in_ready, "R8", {30'b0, out_valid, in_ready}, 32'h1);
    @(negedge clk);
    chk(!out_valid, "R3", {31'b0, out_valid}, 0);
    for (int i = 0; i < 9; i++) frm[i] = 8'h31 + 8'(i);
    send_frame(9, 0, 0, 0);
    chk({got[0], got[1], got[2], got[3]} == 32'h2639F4CB, "R8", {got[0], got[1], got[2], got[3]}, 32'h2639F4CB);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule